// File: doc/BRIEF.md
# Energy Pulse Width Limiter

This block turns a pulse request from a metering engine into a registered output pulse on one pin. When the request rises, the pulse starts. The pulse ends when the request falls or when a maximum number of update ticks has passed, whichever happens first. An update tick lasts a programmable interval times four clock cycles. The tick divider restarts with every pulse, so the width limit is an exact number of clock cycles.

The maximum width always counts an odd number of ticks: a setting of N gives 2N+1 ticks. The all-ones setting turns the limit off. A pulse that the limit cuts short is not restarted while the request stays high. The request has to fall and rise again. The output is active low unless the invert control is set. The block computes no energy. It only reacts to the request pin. There is no data stream, so every pin is a plain level with no handshake.

Top module: `epw_limiter`

## Requirements
- R1: One tick period is P = 4*interval clock cycles. An interval of 0 behaves as 1, so P = 4. The period is counted from the start of each pulse.
- R2: The request is sampled on each rising clock edge. If it stays high for H sampled cycles and no limit applies, the output is active for exactly H cycles.
- R3: The output is registered. It becomes active on the second clock edge after the first edge that samples the request high. It returns to inactive on the second edge after the request is sampled low.
- R4: If max_width = N with N < 255, an active pulse lasts at most (2N+1)*P cycles. A longer request is cut to that length.
- R5: When max_width = 255, no limit applies, and the output follows the request for its full length.
- R6: After a pulse is cut by the limit, the output stays inactive while the request remains high. A new pulse needs the request to be sampled low and then high again.
- R7: The limit is latched when a pulse starts. A change to max_width during a pulse only affects the next pulse.
- R8: The pin is low when active and high when inactive while invert = 0. Setting invert = 1 reverses both levels.
- R9: While rst_n is low, each clock edge drives the pin to its inactive level (the inverse of invert) and clears all pulse state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_req | input | 1 | Pulse request from the metering engine; high asks for an active pulse |
| max_width | input | MAXW_W | Width limit N, giving 2N+1 ticks; all ones disables the limit |
| interval | input | INTERVAL_W | Tick interval; one tick lasts 4*interval cycles (0 counts as 1) |
| invert | input | 1 | 0: active-low pin; 1: active-high pin |
| pulse_out | output | 1 | Registered pulse output pin |

## Verification
The bench uses the default 8-bit limit register, so the limit-off code 255 is tested together with small limits of 0, 1 and 3. The interval is set to 2 (P = 8) and to 0 (P = 4). These short tick periods keep the limit cut-off within a few dozen cycles. This makes it practical to test requests that end just before, exactly at, and long after the limit. Holding the request high long after a cut-off tests that no new pulse starts. Changing max_width in the middle of a pulse tests that the limit was latched at the start.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [1:0] {
    EPW_IDLE    = 2'd0,
    EPW_ACTIVE  = 2'd1,
    EPW_BLOCKED = 2'd2
  } epw_state_e;
endpackage

// File: rtl/epw_tick_div.sv
// Update-tick divider: one tick every 4*interval cycles, restarted per pulse.
module epw_tick_div #(
  parameter int INTERVAL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  run,
  input  logic [INTERVAL_W-1:0] interval,
  output logic                  tick
);
  localparam int CNT_W = INTERVAL_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    if (interval == '0) last = CNT_W'(3);
    else                last = {interval, 2'b00} - CNT_W'(1);
  end

  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (run)          cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
  end

  // R1: the shortest period is four cycles, so two ticks are never adjacent
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/epw_width_ctrl.sv
// Pulse state machine: starts on request, ends on release or on the tick limit.
module epw_width_ctrl
  import epw_pkg::*;
#(
  parameter int MAXW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [MAXW_W-1:0] max_width,
  input  logic              tick,
  output logic              start,
  output logic              run,
  output logic              active
);
  localparam int          TCNT_W  = MAXW_W + 1;
  localparam [MAXW_W-1:0] LIM_OFF = {MAXW_W{1'b1}};

  epw_state_e        state_q;
  logic [MAXW_W-1:0] limit_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic              last_tick;

  assign start     = (state_q == EPW_IDLE) && req;
  assign run       = (state_q == EPW_ACTIVE);
  assign last_tick = tick && (limit_q != LIM_OFF) && (tcnt_q == {limit_q, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EPW_IDLE;
      active  <= 1'b0;
      limit_q <= '0;
      tcnt_q  <= '0;
    end else begin
      case (state_q)
        EPW_IDLE: begin
          if (req) begin
            state_q <= EPW_ACTIVE;
            active  <= 1'b1;
            limit_q <= max_width;
            tcnt_q  <= '0;
          end
        end
        EPW_ACTIVE: begin
          if (!req) begin
            state_q <= EPW_IDLE;
            active  <= 1'b0;
          end else if (last_tick) begin
            state_q <= EPW_BLOCKED;
            active  <= 1'b0;
          end else if (tick && (tcnt_q != {TCNT_W{1'b1}})) begin
            tcnt_q <= tcnt_q + TCNT_W'(1);
          end
        end
        EPW_BLOCKED: begin
          if (!req) state_q <= EPW_IDLE;
        end
        default: begin
          state_q <= EPW_IDLE;
          active  <= 1'b0;
        end
      endcase
    end
  end

  // R2: a release during a pulse ends it at the next edge
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EPW_ACTIVE && !req) |=> !active);
  // R6: a cut pulse is not restarted while the request stays high
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EPW_BLOCKED && req) |=> !active);
  // R7: the latched limit does not move during a pulse
  a_r7_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(limit_q));
  // R4: the tick count never goes past the limit
  a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (limit_q == LIM_OFF || tcnt_q <= {limit_q, 1'b0}));
  // R1: every pulse starts with a cleared tick count
  a_r1_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (tcnt_q == '0));
endmodule

// File: rtl/epw_out_stage.sv
// Registered polarity stage driving the pin.
module epw_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic invert,
  output logic pin
);
  always_ff @(posedge clk) begin
    if (!rst_n) pin <= ~invert;
    else        pin <= ~(active ^ invert);
  end

  // R8: while idle for two edges the pin shows the inactive level
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(active) && $stable(invert)) |-> (pin == ~invert));
endmodule

// File: rtl/epw_limiter.sv
module epw_limiter #(
  parameter int MAXW_W     = 8,
  parameter int INTERVAL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pulse_req,
  input  logic [MAXW_W-1:0]     max_width,
  input  logic [INTERVAL_W-1:0] interval,
  input  logic                  invert,
  output logic                  pulse_out
);
  logic start, run, tick, active;

  epw_tick_div #(.INTERVAL_W(INTERVAL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(run),
    .interval(interval), .tick(tick)
  );

  epw_width_ctrl #(.MAXW_W(MAXW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(pulse_req), .max_width(max_width),
    .tick(tick), .start(start), .run(run), .active(active)
  );

  epw_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .active(active), .invert(invert), .pin(pulse_out)
  );
endmodule

// File: tb/test_epw_limiter.sv
`timescale 1ns/1ps
module test_epw_limiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pulse_req = 1'b0;
  logic [7:0] max_width = 8'd0;
  logic [7:0] interval = 8'd2;
  logic       invert = 1'b0;
  logic       pulse_out;

  int vectors = 0;
  int errors  = 0;
  int exp_q[$];
  int run_len = 0;
  logic inv_d = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  epw_limiter i_epw_limiter (
    .clk(clk), .rst_n(rst_n), .pulse_req(pulse_req), .max_width(max_width),
    .interval(interval), .invert(invert), .pulse_out(pulse_out)
  );

  always @(posedge clk) inv_d <= invert;

  // monitor: measures each active run on the pin and compares with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (inv_d ? pulse_out : ~pulse_out) run_len++;
      else if (run_len > 0) begin
        vectors++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R6: unexpected pulse of %0d cycles, expected none", run_len);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != run_len) begin
            errors++;
            $display("FAIL R2/R4/R5: pulse width %0d, expected %0d", run_len, e);
          end
        end
        run_len = 0;
      end
    end
  end

  // driver: hold the request for h cycles; optionally change max_width midway
  task automatic pulse(input int h, input int n, input int p, input int chg_at, input int chg_val);
    int lim;
    lim = (n == 255) ? h : (2*n + 1) * p;
    exp_q.push_back((h < lim) ? h : lim);
    @(negedge clk);
    max_width = 8'(n);
    pulse_req = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      if (i + 1 == chg_at) max_width = 8'(chg_val);
    end
    pulse_req = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    vectors++;
    if (pulse_out !== ~invert) begin
      errors++;
      $display("FAIL %s: idle pin %b, expected %b", tag, pulse_out, ~invert);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R9");                 // reset level, active low
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R8");
    interval = 8'd2;                  // R1: P = 8
    pulse(5, 0, 8, -1, 0);            // R2: short request
    pulse(8, 0, 8, -1, 0);            // R4: exactly at the limit
    pulse(30, 0, 8, -1, 0);           // R4/R6: cut to 8, held high afterwards
    pulse(23, 1, 8, -1, 0);           // R2: one below 24
    pulse(60, 1, 8, -1, 0);           // R4: cut to 24
    pulse(70, 3, 8, -1, 0);           // R4: cut to 56
    pulse(90, 255, 8, -1, 0);         // R5: no limit
    pulse(40, 0, 8, 3, 5);            // R7: mid-pulse change ignored, cut to 8
    pulse(50, 5, 8, -1, 0);           // R7: new value used next pulse (50 < 88)
    interval = 8'd0;                  // R1: zero interval acts as 1, P = 4
    pulse(30, 1, 4, -1, 0);           // R1: cut to 12
    pulse(1, 0, 4, -1, 0);            // R3: single-cycle request gives one cycle
    invert = 1'b1;                    // R8: active-high
    repeat (3) @(negedge clk);
    check_idle("R8");
    pulse(10, 0, 4, -1, 0);           // R8: cut to 4 in active-high form
    pulse(3, 255, 4, -1, 0);          // R5/R8
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R9");                 // reset level with invert set
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d expected pulses never appeared, expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule